// File: doc/BRIEF.md
# Gatable Astable/Monostable Pulse Generator

This block is a fully synchronous model of a combined free-running and one-shot multivibrator. Analog timing is replaced by cycle counters. An internal tick oscillator has a half-period of `HALF_CYC` clock cycles. The one-shot width is `PULSE_CYC` clock cycles, and its default is about 56 % of the free-running period.

In free-running use, a gate keeps the block running. The gate can be a high-active input or a low-active input. While running, the block produces a square wave on its main output and a faster square wave on the oscillator tap. In one-shot use, a qualified trigger edge produces a single pulse. The edge can be a rising edge on the positive trigger or a falling edge on the negative trigger.

With the retrigger enable set, each new leading edge on the positive trigger stretches the pulse. The pulse then ends on the second rising edge of the oscillator tap that is seen after the last retrigger edge, counting only while the positive trigger is low. A master reset input forces the outputs inactive at any moment. All inputs are assumed to be synchronous to `clk`.

Top module: `mvib_top`

## Requirements
- R1: Free-running mode is active while `gate_hi` is 1 or `gate_lo_n` is 0. In the cycle after the gate is removed, `pulse_q` is 0 and `osc_tap` is 0.
- R2: When free-running mode starts, `pulse_q` goes to 1 after the next clock edge. It stays high for `PULSE_CYC` cycles. After that it toggles every `2*HALF_CYC` cycles.
- R3: Whenever the generator is active, `osc_tap` starts at 0 and toggles every `HALF_CYC` cycles, so its period is half the free-running period of `pulse_q`. While the generator is idle, `osc_tap` is 0.
- R4: `pulse_qn` is always the inverse of `pulse_q`. The reset values are 0 for `pulse_q` and 1 for `pulse_qn`.
- R5: A pulse of `PULSE_CYC` cycles starts on either of two qualified edges, beginning after the next clock edge. The first is a rising edge on `trig_rise` while `trig_fall` is 0. The second is a falling edge on `trig_fall` while `trig_rise` is 1.
- R6: With `retrig_en` at 0, the pulse width does not depend on how long the trigger stays asserted. Further trigger edges during the pulse have no effect.
- R7: With `retrig_en` at 1, each rising edge of `trig_rise` (with `trig_fall` at 0) restarts the oscillator at phase 0. Each such edge also clears the count of tap rises. The pulse ends on the second rising edge of `osc_tap` seen while `trig_rise` is 0. For a trigger shorter than `HALF_CYC`, this gives `3*HALF_CYC` cycles after the last edge.
- R8: While `mreset` is 1, the block is forced idle, with `pulse_q` at 0 and `osc_tap` at 0, and any pulse in progress is cut off. If a trigger edge arrives in the same cycle as `mreset`, the edge is discarded.
- R9: A synchronous `rst` gives `pulse_q`=0, `pulse_qn`=1 and `osc_tap`=0.
- R10: A rising edge of `trig_rise` while `trig_fall` is 1 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_hi | input | 1 | High-active free-running gate |
| gate_lo_n | input | 1 | Low-active free-running gate |
| trig_rise | input | 1 | Positive trigger (rising edge fires) |
| trig_fall | input | 1 | Negative trigger (falling edge fires) |
| retrig_en | input | 1 | Makes positive-trigger edges retrigger |
| mreset | input | 1 | Master reset, forces outputs inactive |
| pulse_q | output | 1 | Main output, true polarity |
| pulse_qn | output | 1 | Main output, complemented |
| osc_tap | output | 1 | Oscillator tap at twice the main rate |

## Verification
The free-running mode is tried twice, once through each gate polarity. Both runs check the same waveform for `pulse_q` and `osc_tap` and then stop the wave, which shows that both gates reach the mode and that the long first half is distinct from the later halves.

One-shot runs use three trigger shapes: a short trigger, a trigger held far longer than the pulse, and a double edge inside the pulse. Together they show that the width is fixed and that extra edges are ignored without the retrigger enable. The negative trigger is driven after a wrongly qualified positive edge, so an output that fires on the wrong qualifier is told apart from one that does not.

Retrigger runs use a single short trigger, a second edge that stretches the pulse, and a trigger held past the first tap rise. These runs expose the rule of counting tap rises only while the trigger is low. Master reset is applied in the middle of a pulse and again together with a trigger edge.

// File: rtl/mvib_pkg.sv
package mvib_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASTB = 2'd1,
        ST_SHOT = 2'd2,
        ST_RTRG = 2'd3
    } mvib_state_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } trig_evt_t;

    // Counter width able to hold values 0..n-1.
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // One-shot width from the oscillator half-period: about 56 % of 4*half.
    function automatic int shot_from_half(input int half);
        return (half * 4 * 56) / 100;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mvib_edge.sv
module mvib_edge
    import mvib_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_pos,
    input  logic      lvl_neg,
    output trig_evt_t evt
);
    localparam int NCH = 2;

    logic [NCH-1:0] lvl;
    logic [NCH-1:0] prev_q;
    logic [NCH-1:0] up;
    logic [NCH-1:0] dn;

    assign lvl = {lvl_neg, lvl_pos};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // During reset the history follows the inputs so no stale edge appears.
        always_ff @(posedge clk) begin
            prev_q[i] <= lvl[i];
        end
        assign up[i] = lvl[i] & ~prev_q[i];
        assign dn[i] = ~lvl[i] & prev_q[i];
    end

    always_comb begin
        evt.pos = up[0] & ~lvl[1];
        evt.neg = dn[1] & lvl[0];
    end

endmodule

// File: rtl/mvib_osc.sv
module mvib_osc
    import mvib_pkg::*;
#(
    parameter int HALF_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic restart,
    output logic tap,
    output logic tap_rise
);
    localparam int CW = cnt_bits(HALF_CYC);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          tap_q;

    always_ff @(posedge clk) begin
        if (rst || clear || restart) begin
            cnt_q <= '0;
            tap_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tap_q <= ~tap_q;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tap      = tap_q;
    assign tap_rise = (cnt_q == LAST) && !tap_q;

    // R3: the tap only moves at the end of a half-period
    assert_tap_steady_R3: assert property (@(posedge clk) disable iff (rst)
        (!clear && !restart && cnt_q != LAST) |=> $stable(tap_q));

    // R3: a cleared oscillator reads low
    assert_tap_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        clear |=> !tap_q);

endmodule

// File: rtl/mvib_span.sv
module mvib_span
    import mvib_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] limit,
    output logic          done
);
    logic [SW-1:0] cnt_q;

    assign done = (cnt_q >= (limit - SW'(1)));

    always_ff @(posedge clk) begin
        if (rst || load || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + SW'(1);
        end
    end

endmodule

// File: rtl/mvib_top.sv
module mvib_top
    import mvib_pkg::*;
#(
    parameter int HALF_CYC  = 5,
    parameter int PULSE_CYC = shot_from_half(HALF_CYC)
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_hi,
    input  logic gate_lo_n,
    input  logic trig_rise,
    input  logic trig_fall,
    input  logic retrig_en,
    input  logic mreset,
    output logic pulse_q,
    output logic pulse_qn,
    output logic osc_tap
);
    localparam int SPAN_MAX = max2(PULSE_CYC, 2 * HALF_CYC);
    localparam int SW       = cnt_bits(SPAN_MAX + 1);
    localparam logic [SW-1:0] LIM_SHOT = SW'(PULSE_CYC);
    localparam logic [SW-1:0] LIM_HALF = SW'(2 * HALF_CYC);

    mvib_state_e st_q, st_d;
    logic        q_q, q_d, qn_q;
    logic        first_q, first_d;
    logic        rcnt_q, rcnt_d;

    trig_evt_t   evt;
    logic        astb_en, fire, re_edge;
    logic        span_load, span_done;
    logic [SW-1:0] span_limit;
    logic        osc_restart, osc_clear, tap, tap_rise;

    assign astb_en = gate_hi | ~gate_lo_n;
    assign fire    = evt.pos | evt.neg;
    assign re_edge = evt.pos & retrig_en;

    mvib_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .lvl_pos (trig_rise),
        .lvl_neg (trig_fall),
        .evt     (evt)
    );

    assign span_limit = (st_q == ST_ASTB && !first_q) ? LIM_HALF : LIM_SHOT;

    mvib_span #(.SW(SW)) u_span (
        .clk   (clk),
        .rst   (rst),
        .load  (span_load),
        .limit (span_limit),
        .done  (span_done)
    );

    mvib_osc #(.HALF_CYC(HALF_CYC)) u_osc (
        .clk      (clk),
        .rst      (rst),
        .clear    (osc_clear),
        .restart  (osc_restart),
        .tap      (tap),
        .tap_rise (tap_rise)
    );

    always_comb begin
        st_d        = st_q;
        q_d         = q_q;
        first_d     = first_q;
        rcnt_d      = rcnt_q;
        span_load   = 1'b0;
        osc_restart = 1'b0;
        if (mreset) begin
            st_d = ST_IDLE;
            q_d  = 1'b0;
        end else if (astb_en) begin
            if (st_q != ST_ASTB) begin
                st_d        = ST_ASTB;
                q_d         = 1'b1;
                first_d     = 1'b1;
                span_load   = 1'b1;
                osc_restart = 1'b1;
            end else if (span_done) begin
                q_d     = ~q_q;
                first_d = 1'b0;
            end
        end else begin
            case (st_q)
                ST_ASTB: begin
                    st_d = ST_IDLE;
                    q_d  = 1'b0;
                end
                ST_IDLE: begin
                    if (fire) begin
                        q_d         = 1'b1;
                        osc_restart = 1'b1;
                        span_load   = 1'b1;
                        rcnt_d      = 1'b0;
                        st_d        = re_edge ? ST_RTRG : ST_SHOT;
                    end
                end
                ST_SHOT: begin
                    if (re_edge) begin
                        st_d        = ST_RTRG;
                        osc_restart = 1'b1;
                        rcnt_d      = 1'b0;
                    end else if (span_done) begin
                        st_d = ST_IDLE;
                        q_d  = 1'b0;
                    end
                end
                ST_RTRG: begin
                    if (re_edge) begin
                        osc_restart = 1'b1;
                        rcnt_d      = 1'b0;
                    end else if (tap_rise && !trig_rise) begin
                        if (rcnt_q) begin
                            st_d = ST_IDLE;
                            q_d  = 1'b0;
                        end else begin
                            rcnt_d = 1'b1;
                        end
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                    q_d  = 1'b0;
                end
            endcase
        end
    end

    assign osc_clear = (st_d == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            q_q     <= 1'b0;
            qn_q    <= 1'b1;
            first_q <= 1'b0;
            rcnt_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            q_q     <= q_d;
            qn_q    <= ~q_d;
            first_q <= first_d;
            rcnt_q  <= rcnt_d;
        end
    end

    assign pulse_q  = q_q;
    assign pulse_qn = qn_q;
    assign osc_tap  = tap;

    // R4: the two output flops never agree
    assert_qn_inverse_R4: assert property (@(posedge clk) disable iff (rst)
        pulse_qn == ~pulse_q);

    // R8: master reset silences the output on the next cycle
    assert_mreset_off_R8: assert property (@(posedge clk) disable iff (rst)
        mreset |=> (!pulse_q && !osc_tap));

    // R1: dropping the gate stops the wave
    assert_gate_stop_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ASTB && !astb_en) |=> (!pulse_q && !osc_tap));

    // R6: a plain one-shot holds until its width elapses
    assert_shot_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHOT && !span_done && !mreset && !astb_en) |=> pulse_q);

    // R7: a retriggered pulse holds while the trigger is high
    assert_retrig_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RTRG && trig_rise && !mreset && !astb_en) |=> pulse_q);

endmodule

// File: tb/sim_mvib_top.sv
module sim_mvib_top;
    localparam int H = 5;
    localparam int P = 11;

    typedef struct {
        logic  q;
        logic  chk_tap;
        logic  tap;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst, gate_hi, gate_lo_n, trig_rise, trig_fall, retrig_en, mreset;
    logic pulse_q, pulse_qn, osc_tap;

    int   n_vec  = 0;
    int   n_fail = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    mvib_top #(.HALF_CYC(H), .PULSE_CYC(P)) u0 (
        .clk(clk), .rst(rst), .gate_hi(gate_hi), .gate_lo_n(gate_lo_n),
        .trig_rise(trig_rise), .trig_fall(trig_fall), .retrig_en(retrig_en),
        .mreset(mreset), .pulse_q(pulse_q), .pulse_qn(pulse_qn), .osc_tap(osc_tap)
    );

    task automatic push(input logic q, input logic ct, input logic t, input string tag);
        exp_t e;
        e.q = q; e.chk_tap = ct; e.tap = t; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push(1'b0, 1'b1, 1'b0, tag);
        end
    endtask

    function automatic logic astb_q(input int c);
        if (c < P) return 1'b1;
        return (((c - P) / (2 * H)) % 2 == 0) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic tap_at(input int c);
        return ((c / H) % 2 == 1) ? 1'b1 : 1'b0;
    endfunction

    // Monitor: samples 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (pulse_q !== e.q) begin
                    n_fail++;
                    $display("FAIL %s pulse_q got %b exp %b", e.tag, pulse_q, e.q);
                end
                if (pulse_qn !== ~e.q) begin
                    n_fail++;
                    $display("FAIL R4 (%s) pulse_qn got %b exp %b", e.tag, pulse_qn, ~e.q);
                end
                if (e.chk_tap && osc_tap !== e.tap) begin
                    n_fail++;
                    $display("FAIL %s osc_tap got %b exp %b", e.tag, osc_tap, e.tap);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired got running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; gate_hi = 1'b0; gate_lo_n = 1'b1; trig_rise = 1'b0;
        trig_fall = 1'b0; retrig_en = 1'b0; mreset = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            push(1'b0, 1'b1, 1'b0, "R9 reset state");
        end
        @(negedge clk); rst = 1'b0; push(1'b0, 1'b1, 1'b0, "R9 after reset");
        idle(3, "R9 idle");

        // R2 R3 free-running through the high gate
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            gate_hi = 1'b1;
            push(astb_q(c), 1'b1, tap_at(c), "R2 R3 astable via gate_hi");
        end
        @(negedge clk); gate_hi = 1'b0; push(1'b0, 1'b1, 1'b0, "R1 gate removed");
        idle(4, "R1 stopped");

        // R1 free-running through the low-active gate
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            gate_lo_n = 1'b0;
            push(astb_q(c), 1'b1, tap_at(c), "R1 astable via gate_lo_n");
        end
        @(negedge clk); gate_lo_n = 1'b1; push(1'b0, 1'b1, 1'b0, "R1 gate_lo_n removed");
        idle(4, "R1 stopped");

        // R5 short positive trigger
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            trig_rise = (c < 2);
            push(c < P, 1'b0, 1'b0, "R5 positive trigger width");
        end
        idle(3, "R5 idle");

        // R6 trigger held much longer than the pulse
        for (int c = 0; c < 34; c++) begin
            @(negedge clk);
            trig_rise = (c < 30);
            push(c < P, 1'b0, 1'b0, "R6 long trigger same width");
        end
        idle(3, "R6 idle");

        // R6 second edge during a plain pulse is ignored
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            trig_rise = (c < 2) || (c >= 4 && c < 6);
            push(c < P, 1'b0, 1'b0, "R6 extra edge ignored");
        end
        idle(3, "R6 idle");

        // R10 wrongly qualified positive edge, then R5 negative trigger
        for (int c = 0; c < 22; c++) begin
            @(negedge clk);
            trig_fall = (c < 5);
            trig_rise = (c >= 2);
            if (c < 5) push(1'b0, 1'b0, 1'b0, "R10 positive edge with trig_fall high");
            else       push((c - 5) < P, 1'b0, 1'b0, "R5 negative trigger width");
        end
        @(negedge clk); trig_rise = 1'b0; push(1'b0, 1'b0, 1'b0, "R5 no edge on release");
        idle(3, "R5 idle");

        // R7 single short retrigger pulse: 3*H cycles, tap from phase 0
        @(negedge clk); retrig_en = 1'b1; push(1'b0, 1'b1, 1'b0, "R7 idle");
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            trig_rise = (c < 2);
            push(c < 3 * H, 1'b1, (c < 3 * H) ? tap_at(c) : 1'b0, "R7 single retrigger");
        end
        idle(3, "R7 idle");

        // R7 second edge stretches the pulse
        for (int c = 0; c < 26; c++) begin
            @(negedge clk);
            trig_rise = (c < 2) || (c >= 6 && c < 8);
            push(c < 6 + 3 * H, 1'b0, 1'b0, "R7 retrigger extends");
        end
        idle(3, "R7 idle");

        // R7 tap rise while trigger high is not counted
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            trig_rise = (c < 8);
            push(c < 5 * H, 1'b0, 1'b0, "R7 rise under high trigger skipped");
        end
        idle(3, "R7 idle");
        @(negedge clk); retrig_en = 1'b0; push(1'b0, 1'b1, 1'b0, "R7 idle");

        // R8 master reset cuts a pulse
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            trig_rise = (c < 2);
            mreset    = (c == 4);
            push(c < 4, 1'b1, (c < 4) ? tap_at(c) : 1'b0, "R8 mreset cuts pulse");
        end
        idle(3, "R8 idle");

        // R8 master reset wins over a simultaneous edge
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            mreset    = (c == 0);
            trig_rise = (c < 6);
            push(1'b0, 1'b1, 1'b0, "R8 edge with mreset discarded");
        end
        idle(4, "R8 idle");

        while (sb.size() > 0) @(posedge clk);
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule